// File: doc/BRIEF.md
# Sequenced Mode Register Bank

This block holds three mode registers for each serial channel, called slot 0, slot 1 and slot 2. A CPU reaches all three through one shared bus address per channel. A hidden per-channel pointer decides which slot the next read or write touches. Each completed access moves the pointer forward by one slot. Once the pointer reaches slot 2 it stops there, so repeated accesses keep reaching slot 2.

Software rewinds the pointer in one of three ways: through reset, through a command that moves it back to slot 0, or through a command that moves it to slot 1. A driver normally rewinds to slot 0 and then writes three bytes back to back to configure a channel. The register values and the pointer of every channel are brought out as plain outputs for the channel logic, which decodes the fields.

In the second channel (index 1), bits 3:0 of slot 0 are reserved. They always read 0 and ignore writes.

Top module: `mode_reg_bank`

## Requirements
- R1: While reset is low at a rising clock edge, every channel's pointer becomes slot 0 and every register becomes 0. Pointer encoding on `ptr_state`: 2'b00 means slot 0, 2'b01 means slot 1, 2'b10 means slot 2, and 2'b11 never appears.
- R2: An access is a cycle with `bus_cs` high and `bus_rd` or `bus_wr` high, addressed to the channel given by `bus_chan`. An access to a channel whose pointer is at slot 0, with no set command for that channel, moves its pointer to slot 1 at the next edge.
- R3: An access to a channel whose pointer is at slot 1, with no set command, moves its pointer to slot 2 at the next edge.
- R4: An access to a channel whose pointer is at slot 2, with no set command, leaves the pointer at slot 2.
- R5: A write (`bus_cs` and `bus_wr` high) stores `bus_wdata` into the slot that the addressed channel's pointer selects before the advance. The new value appears on the register output after that edge. The other slots keep their values.
- R6: While `bus_cs` and `bus_rd` are high, `bus_rdata` combinationally shows the slot that the addressed channel's pointer selects. In any other cycle `bus_rdata` is 0.
- R7: `set_ptr_m0[c]` high moves channel c's pointer to slot 0 at the next edge. It overrides any advance and also overrides `set_ptr_m1[c]`.
- R8: `set_ptr_m1[c]` high, with `set_ptr_m0[c]` low, moves channel c's pointer to slot 1 at the next edge and overrides any advance.
- R9: In channel 1, bits 3:0 of slot 0 always read 0 and are never changed by a write.
- R10: An access or set command for one channel leaves the other channel's pointer and registers unchanged.
- R11: A cycle with no access to a channel and no set command for it leaves that channel's pointer unchanged. Reads never change register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_chan | input | CHW (1) | Channel addressed by the access |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data, combinational |
| set_ptr_m0 | input | NUM_CH (2) | Per-channel command: move the pointer to slot 0 |
| set_ptr_m1 | input | NUM_CH (2) | Per-channel command: move the pointer to slot 1 |
| mode0_q | output | NUM_CH*DW (16) | Slot 0 values; channel c at bits [c*DW +: DW] |
| mode1_q | output | NUM_CH*DW (16) | Slot 1 values, same packing |
| mode2_q | output | NUM_CH*DW (16) | Slot 2 values, same packing |
| ptr_state | output | NUM_CH*2 (4) | Pointer per channel; channel c at bits [c*2 +: 2] |

## Verification
Read data is due in the same cycle as the read strobe, so the bench checks it a short delay after driving the inputs and before the clock edge. Pointer moves and written register values are due one edge after the access or command. The bench updates its behavioural model at that edge and compares every register and pointer output just after it, on every clock. Directed sequences cover the slot walk, the stop at slot 2, command priority, the reserved bits and channel isolation. A random phase then mixes accesses and commands.

// File: rtl/mrp_pkg.sv
// Package: shared pointer type for the mode register bank.
// Assumes a fixed three-slot sequence per channel.
package mrp_pkg;
    typedef enum logic [1:0] {
        SLOT0 = 2'b00,
        SLOT1 = 2'b01,
        SLOT2 = 2'b10
    } slot_e;
endpackage

// File: rtl/mrp_pointer.sv
// Module: per-channel slot pointer.
// Moves forward one slot per access and stops at the last slot. A set command
// wins over the advance, and the slot-0 command wins over the slot-1 command.
// Assumes acc_i is already qualified for this channel.
module mrp_pointer
    import mrp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  acc_i,
    input  logic  set_m0_i,
    input  logic  set_m1_i,
    output slot_e ptr_o
);
    slot_e ptr_q;
    slot_e ptr_d;

    // Next-slot selection with command priority.
    always_comb begin
        ptr_d = ptr_q;
        if (set_m0_i) begin
            ptr_d = SLOT0;
        end else if (set_m1_i) begin
            ptr_d = SLOT1;
        end else if (acc_i) begin
            case (ptr_q)
                SLOT0:   ptr_d = SLOT1;
                SLOT1:   ptr_d = SLOT2;
                default: ptr_d = SLOT2;
            endcase
        end
    end

    // Pointer register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= SLOT0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    // R1
    ptr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q != 2'b11);
    // R2
    ptr_s0_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !set_m0_i && !set_m1_i && ptr_q == SLOT0) |=> ptr_q == SLOT1);
    // R3
    ptr_s1_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !set_m0_i && !set_m1_i && ptr_q == SLOT1) |=> ptr_q == SLOT2);
    // R4
    ptr_s2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_m0_i && !set_m1_i && ptr_q == SLOT2) |=> ptr_q == SLOT2);
    // R7
    ptr_set0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_m0_i |=> ptr_q == SLOT0);
    // R8
    ptr_set1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m1_i && !set_m0_i) |=> ptr_q == SLOT1);
    // R11
    ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_i && !set_m0_i && !set_m1_i) |=> $stable(ptr_q));
endmodule

// File: rtl/mrp_regfile.sv
// Module: the three mode registers of one channel.
// The write goes to the slot that sel_i names. Bits set in RSV_MASK0 are
// reserved in slot 0: they are held at 0 and ignore writes.
module mrp_regfile
    import mrp_pkg::*;
#(
    parameter int unsigned   DW        = 8,
    parameter logic [DW-1:0] RSV_MASK0 = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  slot_e         sel_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] m0_o,
    output logic [DW-1:0] m1_o,
    output logic [DW-1:0] m2_o
);
    localparam logic [DW-1:0] KEEP0 = ~RSV_MASK0;

    logic [DW-1:0] m0_q, m1_q, m2_q;

    // Slot 0 storage, with the reserved bits forced to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                         m0_q <= '0;
        else if (wr_en_i && sel_i == SLOT0) m0_q <= wdata_i & KEEP0;
    end

    // Slot 1 storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                         m1_q <= '0;
        else if (wr_en_i && sel_i == SLOT1) m1_q <= wdata_i;
    end

    // Slot 2 storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                         m2_q <= '0;
        else if (wr_en_i && sel_i == SLOT2) m2_q <= wdata_i;
    end

    assign m0_o = m0_q;
    assign m1_o = m1_q;
    assign m2_o = m2_q;

    // R5
    wr_s1_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == SLOT1) |=> m1_q == $past(wdata_i));
    // R5
    wr_s2_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == SLOT2) |=> ($stable(m0_q) && $stable(m1_q)));
    // R9
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_q & RSV_MASK0) == '0);
    // R11
    no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(m0_q) && $stable(m1_q) && $stable(m2_q)));
endmodule

// File: rtl/mrp_rdmux.sv
// Module: read-data selection across channels.
// Shows the slot named by the addressed channel's pointer while a read is
// active, and 0 otherwise. The result is combinational.
module mrp_rdmux
    import mrp_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned DW     = 8,
    parameter int unsigned CHW    = 1
) (
    input  logic                 rd_en_i,
    input  logic [CHW-1:0]       chan_i,
    input  logic [NUM_CH*DW-1:0] m0_i,
    input  logic [NUM_CH*DW-1:0] m1_i,
    input  logic [NUM_CH*DW-1:0] m2_i,
    input  logic [NUM_CH*2-1:0]  ptr_i,
    output logic [DW-1:0]        rdata_o
);
    // Pick the channel, then the slot.
    always_comb begin
        rdata_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_en_i && chan_i == CHW'(c)) begin
                case (ptr_i[c*2 +: 2])
                    2'b00:   rdata_o = m0_i[c*DW +: DW];
                    2'b01:   rdata_o = m1_i[c*DW +: DW];
                    default: rdata_o = m2_i[c*DW +: DW];
                endcase
            end
        end
    end

    // R6
    rd_idle_zero_chk: assert final (rd_en_i || rdata_o == '0);
endmodule

// File: rtl/mode_reg_bank.sv
// Module: top of the sequenced mode register bank.
// Each channel has its own pointer and three registers behind one shared
// address. Channel 1 reserves bits RSV_BITS-1:0 of slot 0.
// Assumes the strobes are single-cycle qualified by bus_cs.
module mode_reg_bank
    import mrp_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned DW       = 8,
    parameter int unsigned RSV_CH   = 1,
    parameter int unsigned RSV_BITS = 4,
    localparam int unsigned CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_cs,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [CHW-1:0]       bus_chan,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NUM_CH-1:0]    set_ptr_m0,
    input  logic [NUM_CH-1:0]    set_ptr_m1,
    output logic [NUM_CH*DW-1:0] mode0_q,
    output logic [NUM_CH*DW-1:0] mode1_q,
    output logic [NUM_CH*DW-1:0] mode2_q,
    output logic [NUM_CH*2-1:0]  ptr_state
);
    localparam logic [DW-1:0] RSV_MASK = DW'((1 << RSV_BITS) - 1);

    logic acc_any;
    logic wr_any;
    logic rd_any;

    // Qualify the strobes with the chip select.
    always_comb begin
        rd_any  = bus_cs && bus_rd;
        wr_any  = bus_cs && bus_wr;
        acc_any = rd_any || wr_any;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [DW-1:0] MASK_C = (c == RSV_CH) ? RSV_MASK : '0;
        logic  hit;
        slot_e ptr;

        // Decode the access to this channel.
        always_comb hit = (bus_chan == CHW'(c));

        mrp_pointer u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_i    (acc_any && hit),
            .set_m0_i (set_ptr_m0[c]),
            .set_m1_i (set_ptr_m1[c]),
            .ptr_o    (ptr)
        );

        mrp_regfile #(.DW(DW), .RSV_MASK0(MASK_C)) u_rf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (wr_any && hit),
            .sel_i   (ptr),
            .wdata_i (bus_wdata),
            .m0_o    (mode0_q[c*DW +: DW]),
            .m1_o    (mode1_q[c*DW +: DW]),
            .m2_o    (mode2_q[c*DW +: DW])
        );

        assign ptr_state[c*2 +: 2] = ptr;

        // R10
        ch_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(acc_any && hit) && !set_ptr_m0[c] && !set_ptr_m1[c])
            |=> ($stable(ptr_state[c*2 +: 2]) && $stable(mode0_q[c*DW +: DW])));
    end

    mrp_rdmux #(.NUM_CH(NUM_CH), .DW(DW), .CHW(CHW)) u_rd (
        .rd_en_i (rd_any),
        .chan_i  (bus_chan),
        .m0_i    (mode0_q),
        .m1_i    (mode1_q),
        .m2_i    (mode2_q),
        .ptr_i   (ptr_state),
        .rdata_o (bus_rdata)
    );
endmodule

// File: tb/mode_reg_bank_tb.sv
module mode_reg_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [0:0] bus_chan = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] set_ptr_m0 = '0, set_ptr_m1 = '0;
    logic [15:0] mode0_q, mode1_q, mode2_q;
    logic [3:0]  ptr_state;

    int checks = 0;
    int failures = 0;
    int mptr [NCH];
    int mreg [NCH][3];

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_reg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_chan(bus_chan), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .set_ptr_m0(set_ptr_m0), .set_ptr_m1(set_ptr_m1),
        .mode0_q(mode0_q), .mode1_q(mode1_q), .mode2_q(mode2_q),
        .ptr_state(ptr_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every pointer and register against the model.
    task automatic cmp_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            chk(req, int'(ptr_state[c*2 +: 2]), mptr[c]);
            chk(req, int'(mode0_q[c*8 +: 8]), mreg[c][0]);
            chk(req, int'(mode1_q[c*8 +: 8]), mreg[c][1]);
            chk(req, int'(mode2_q[c*8 +: 8]), mreg[c][2]);
        end
    endtask

    // One clock: drive, check read data, advance the model, compare.
    task automatic step(input string req, input bit cs, input bit rd, input bit wr,
                        input int ch, input int wd, input int c0, input int c1);
        int  exp_rd;
        bit  acc;
        @(negedge clk);
        bus_cs = cs; bus_rd = rd; bus_wr = wr; bus_chan = 1'(ch);
        bus_wdata = 8'(wd); set_ptr_m0 = 2'(c0); set_ptr_m1 = 2'(c1);
        #1;
        exp_rd = (cs && rd) ? mreg[ch][mptr[ch]] : 0;
        chk({req, " R6 rdata"}, int'(bus_rdata), exp_rd);
        @(posedge clk);
        acc = cs && (rd || wr);
        if (cs && wr) mreg[ch][mptr[ch]] = (ch == 1 && mptr[ch] == 0) ? (wd & 8'hF0) : (wd & 8'hFF);
        for (int c = 0; c < NCH; c++) begin
            if (c0[c])                         mptr[c] = 0;
            else if (c1[c])                    mptr[c] = 1;
            else if (acc && ch == c && mptr[c] < 2) mptr[c] = mptr[c] + 1;
        end
        #1;
        cmp_all(req);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            mptr[c] = 0;
            for (int s = 0; s < 3; s++) mreg[c][s] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        cmp_all("R1 reset");
        @(negedge clk); rst_n = 1'b1;

        // R2 R3 R4 R5: write the slots of channel 0 in sequence, then keep hitting slot 2.
        step("R2 wr s0", 1, 0, 1, 0, 8'hA1, 0, 0);
        step("R3 wr s1", 1, 0, 1, 0, 8'hB2, 0, 0);
        step("R5 wr s2", 1, 0, 1, 0, 8'hC3, 0, 0);
        step("R4 wr s2 again", 1, 0, 1, 0, 8'hD4, 0, 0);
        step("R4 rd s2", 1, 1, 0, 0, 0, 0, 0);
        // R11: no strobe or no chip select leaves everything alone.
        step("R11 idle", 0, 1, 1, 0, 8'h55, 0, 0);
        step("R11 cs only", 1, 0, 0, 0, 8'h55, 0, 0);
        // R7: rewind to slot 0 and read the slots back.
        step("R7 set0", 0, 0, 0, 0, 0, 1, 0);
        step("R6 rd s0", 1, 1, 0, 0, 0, 0, 0);
        step("R6 rd s1", 1, 1, 0, 0, 0, 0, 0);
        // R8: move to slot 1 during an access, so the command wins over the advance.
        step("R8 set1 with access", 1, 1, 0, 0, 0, 0, 1);
        step("R7 both cmds", 1, 0, 1, 0, 8'h77, 1, 1);
        // R9: reserved bits of channel 1 slot 0.
        step("R9 wr ch1 s0", 1, 0, 1, 1, 8'hFF, 0, 0);
        step("R10 ch1 s1", 1, 0, 1, 1, 8'h3C, 0, 0);
        step("R9 set0 ch1", 0, 0, 0, 1, 0, 2, 0);
        step("R9 rd ch1 s0", 1, 1, 0, 1, 0, 0, 0);
        // R10: commands on one channel only.
        step("R10 set1 ch0 only", 1, 0, 1, 1, 8'h99, 0, 1);

        // Random mix of accesses and commands.
        for (int i = 0; i < 2000; i++) begin
            int r = int'($urandom);
            step("R10 random", r[0] | r[1], r[2], r[3], r[4], r[15:8],
                 (r[7:5] == 0) ? r[17:16] : 0, (r[20:18] == 0) ? r[22:21] : 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule